// File: doc/BRIEF.md
# Indexed Effective Address Generator

This block forms the 24-bit data address for the operand access of an 8/16-bit accumulator-style processor core. It takes the operand bytes already collected from the instruction stream, the two index registers, the 16-bit direct-page base, the data bank and two mode flags. A 4-bit code selects the addressing mode. The result is registered, so it is ready one clock after the inputs are presented.

The block also tells the sequencer whether the next bus cycle may be dropped. For absolute-indexed reads, that cycle is the penalty cycle taken when indexing crosses a page. For direct-page modes, it is the extra cycle taken when the direct base is not page-aligned. For absolute-indexed modes the block also gives the address of the dummy read that the bus makes in the penalty cycle. That address keeps the page byte of the unindexed operand and takes the low byte of the indexed sum.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ea_addr`, `dummy_addr` and `skip_next` are all zero after that edge.
- R2: The outputs change only at a rising edge. They reflect the inputs sampled at the previous rising edge, so a change of inputs between edges leaves the outputs unchanged.
- R3: Mode code 0 (absolute) gives `ea_addr` = data bank byte, then `op_hi`, then `op_lo`. For this mode `skip_next` = 0 and `dummy_addr` = 0.
- R4: Codes 1 and 2 index by X, and codes 3 and 4 index by Y. For these, `ea_addr` = `data_bank` + {`op_hi`,`op_lo`} + index, taken modulo 2^24, so a carry out of bit 15 increments the bank byte. `data_bank` carries the bank in bits 23:16 and zero in bits 15:0.
- R5: Codes 2 and 4 (indexed reads) set `skip_next` to 1 exactly when two conditions both hold. First, `op_lo` plus the index low byte makes no carry out of bit 7. Second, `emu_mode` or `idx8_mode` is 1.
- R6: Codes 1 and 3 (indexed write / read-modify-write) always give `skip_next` = 0.
- R7: For codes 1 to 4, `dummy_addr` = {bank byte, `op_hi`, low byte of (`op_lo` + index)}. For every other code, `dummy_addr` is zero.
- R8: Direct codes give bits 15:0 of `ea_addr` as follows, taken modulo 2^16, with bits 23:16 = 0. Code 5 gives `dp_reg` + `op_lo`. Code 6 gives `dp_reg` + `op_lo` + X. Code 7 gives `dp_reg` + `op_lo` + Y. Code 8 (X-indexed pointer) gives `dp_reg` + `op_lo` + X. Code 9 (pointer) gives `dp_reg` + `op_lo`.
- R9: Direct codes 5 to 9 give `skip_next` = 1 exactly when `dp_reg[7:0]` is zero.
- R10: Codes 10 to 15 give `ea_addr` = 0, `dummy_addr` = 0 and `skip_next` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 4 | Addressing-mode code |
| op_lo | input | 8 | First operand byte |
| op_hi | input | 8 | Second operand byte |
| x_idx | input | 16 | X index value |
| y_idx | input | 16 | Y index value |
| dp_reg | input | 16 | Direct-page base |
| data_bank | input | 24 | Data bank, pre-shifted into bits 23:16 |
| emu_mode | input | 1 | Emulation mode flag |
| idx8_mode | input | 1 | 8-bit index flag |
| ea_addr | output | 24 | Registered effective address |
| dummy_addr | output | 24 | Registered dummy-read address |
| skip_next | output | 1 | Registered: the next penalty cycle may be dropped |

## Verification
The assertions take three things for granted. The low 16 bits of `data_bank` are zero. When `idx8_mode` or `emu_mode` is set, the high bytes of both index registers are zero. Under that second condition, a skipped indexed read has the same page byte in `ea_addr` and `dummy_addr`. All stimulus keeps to these conditions: every bank value is written as a byte and shifted in, and any vector with a 16-bit index value clears both mode flags. The page-cross, bank-carry, direct-wrap and unused-code cases are each driven on purpose.

// File: rtl/eag_pkg.sv
// Package: mode codes and mode-class helpers for the address generator.
// Assumes mode codes are 4 bits wide; codes above AM_DIR_PTR are unused.
package eag_pkg;
    localparam logic [3:0] AM_ABS       = 4'd0;
    localparam logic [3:0] AM_ABS_X     = 4'd1;
    localparam logic [3:0] AM_ABS_X_RD  = 4'd2;
    localparam logic [3:0] AM_ABS_Y     = 4'd3;
    localparam logic [3:0] AM_ABS_Y_RD  = 4'd4;
    localparam logic [3:0] AM_DIR       = 4'd5;
    localparam logic [3:0] AM_DIR_X     = 4'd6;
    localparam logic [3:0] AM_DIR_Y     = 4'd7;
    localparam logic [3:0] AM_DIR_X_PTR = 4'd8;
    localparam logic [3:0] AM_DIR_PTR   = 4'd9;

    // True for the four absolute-indexed codes.
    function automatic logic is_abs_idx(input logic [3:0] m);
        return (m >= AM_ABS_X) && (m <= AM_ABS_Y_RD);
    endfunction

    // True for the indexed read codes, which may drop the penalty cycle.
    function automatic logic is_idx_read(input logic [3:0] m);
        return (m == AM_ABS_X_RD) || (m == AM_ABS_Y_RD);
    endfunction

    // True for every direct-page code.
    function automatic logic is_direct(input logic [3:0] m);
        return (m >= AM_DIR) && (m <= AM_DIR_PTR);
    endfunction

    // True when the index source is Y rather than X.
    function automatic logic uses_y(input logic [3:0] m);
        return (m == AM_ABS_Y) || (m == AM_ABS_Y_RD) || (m == AM_DIR_Y);
    endfunction
endpackage

// File: rtl/eag_abs_idx.sv
// Absolute-indexed address path. Adds the index to the 16-bit operand,
// adds the result into the pre-shifted bank, and builds the dummy address
// from the bank, the base page byte and the indexed low byte.
// Assumes bank[OFS_W-1:0] is zero.
module eag_abs_idx #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [OFS_W-1:0]  base,
    input  logic [OFS_W-1:0]  idx,
    input  logic [ADDR_W-1:0] bank,
    output logic [ADDR_W-1:0] ea,
    output logic [ADDR_W-1:0] dummy,
    output logic              lo_carry
);
    localparam int BANK_W = ADDR_W - OFS_W;

    logic [OFS_W:0]  sum_full;
    logic [BYTE_W:0] lo_sum;

    // Full sum with carry, carried into the bank field.
    always_comb begin
        sum_full = {1'b0, base} + {1'b0, idx};
        ea       = bank + {{(BANK_W-1){1'b0}}, sum_full};
    end

    // Low-byte carry and the mixed-page dummy address.
    always_comb begin
        lo_sum   = {1'b0, base[BYTE_W-1:0]} + {1'b0, idx[BYTE_W-1:0]};
        lo_carry = lo_sum[BYTE_W];
        dummy    = {bank[ADDR_W-1:OFS_W], base[OFS_W-1:BYTE_W], lo_sum[BYTE_W-1:0]};
    end
endmodule

// File: rtl/eag_direct.sv
// Direct-page address path. Adds the operand byte and an optional index
// to the direct base, wraps at 16 bits and forces the bank to zero.
// It also flags a page-aligned direct base.
module eag_direct #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [OFS_W-1:0]  dp,
    input  logic [BYTE_W-1:0] off,
    input  logic [OFS_W-1:0]  idx,
    input  logic              use_idx,
    output logic [ADDR_W-1:0] ea,
    output logic              dp_lo_zero
);
    localparam int BANK_W = ADDR_W - OFS_W;

    logic [OFS_W-1:0] ofs;

    // Wrapped 16-bit direct offset, with the bank forced to zero.
    always_comb begin
        ofs = dp + {{(OFS_W-BYTE_W){1'b0}}, off} + (use_idx ? idx : '0);
        ea  = {{BANK_W{1'b0}}, ofs};
    end

    // Page-aligned direct base lets the sequencer drop the extra cycle.
    always_comb dp_lo_zero = (dp[BYTE_W-1:0] == '0);
endmodule

// File: rtl/eag_top.sv
// Effective address generator top. Decodes the mode code, selects between
// the absolute-indexed and direct paths, and registers the address, the
// dummy address and the skip flag.
// Assumes: data_bank[15:0] is zero. When emu_mode or idx8_mode is set,
// the index high bytes are zero.
module eag_top #(
    parameter int ADDR_W = 24,
    parameter int OFS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        mode_sel,
    input  logic [BYTE_W-1:0] op_lo,
    input  logic [BYTE_W-1:0] op_hi,
    input  logic [OFS_W-1:0]  x_idx,
    input  logic [OFS_W-1:0]  y_idx,
    input  logic [OFS_W-1:0]  dp_reg,
    input  logic [ADDR_W-1:0] data_bank,
    input  logic              emu_mode,
    input  logic              idx8_mode,
    output logic [ADDR_W-1:0] ea_addr,
    output logic [ADDR_W-1:0] dummy_addr,
    output logic              skip_next
);
    import eag_pkg::*;

    logic [OFS_W-1:0]  sel_idx;
    logic [ADDR_W-1:0] abs_ea, abs_dummy, dir_ea;
    logic              abs_lo_carry, dir_lo_zero, dir_use_idx;
    logic [ADDR_W-1:0] ea_d, dummy_d;
    logic              skip_d;
    logic              primed_q;

    // Index source chosen by the mode code.
    always_comb sel_idx = uses_y(mode_sel) ? y_idx : x_idx;

    // Direct codes that add an index register.
    always_comb dir_use_idx = (mode_sel == AM_DIR_X) || (mode_sel == AM_DIR_Y) ||
                              (mode_sel == AM_DIR_X_PTR);

    eag_abs_idx #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) abs_i (
        .base     ({op_hi, op_lo}),
        .idx      (sel_idx),
        .bank     (data_bank),
        .ea       (abs_ea),
        .dummy    (abs_dummy),
        .lo_carry (abs_lo_carry)
    );

    eag_direct #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .BYTE_W(BYTE_W)) dir_i (
        .dp         (dp_reg),
        .off        (op_lo),
        .idx        (sel_idx),
        .use_idx    (dir_use_idx),
        .ea         (dir_ea),
        .dp_lo_zero (dir_lo_zero)
    );

    // Mode mux: selects the address, dummy address and skip for this code.
    always_comb begin
        ea_d    = '0;
        dummy_d = '0;
        skip_d  = 1'b0;
        if (mode_sel == AM_ABS) begin
            ea_d = data_bank | {{(ADDR_W-OFS_W){1'b0}}, op_hi, op_lo};
        end else if (is_abs_idx(mode_sel)) begin
            ea_d    = abs_ea;
            dummy_d = abs_dummy;
            skip_d  = is_idx_read(mode_sel) && !abs_lo_carry && (emu_mode || idx8_mode);
        end else if (is_direct(mode_sel)) begin
            ea_d   = dir_ea;
            skip_d = dir_lo_zero;
        end
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_addr    <= '0;
            dummy_addr <= '0;
            skip_next  <= 1'b0;
        end else begin
            ea_addr    <= ea_d;
            dummy_addr <= dummy_d;
            skip_next  <= skip_d;
        end
    end

    // Marks that the previous edge was out of reset, so the outputs are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    // The bank input keeps its low 16 bits clear.
    assert_bank_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_bank[OFS_W-1:0] == '0);

    // Unused codes produce all-zero outputs.
    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && ($past(mode_sel) > AM_DIR_PTR)) |->
        (ea_addr == '0 && dummy_addr == '0 && !skip_next));

    // Direct codes never leave bank 0.
    assert_direct_bank_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && is_direct($past(mode_sel))) |->
        (ea_addr[ADDR_W-1:OFS_W] == '0 && dummy_addr == '0));

    // Skip comes only from indexed reads or direct codes.
    assert_skip_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && skip_next) |->
        (is_idx_read($past(mode_sel)) || is_direct($past(mode_sel))));

    // A skipped indexed read stays in the page of the dummy read.
    assert_skip_same_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && skip_next && is_idx_read($past(mode_sel))) |->
        (ea_addr[OFS_W-1:BYTE_W] == dummy_addr[OFS_W-1:BYTE_W]));

    // Direct skip follows the low byte of the direct base.
    assert_direct_skip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && is_direct($past(mode_sel))) |->
        (skip_next == ($past(dp_reg[BYTE_W-1:0]) == '0)));
endmodule

// File: tb/eag_top_tb_top.sv
module eag_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  mode_sel;
    logic [7:0]  op_lo, op_hi;
    logic [15:0] x_idx, y_idx, dp_reg;
    logic [23:0] data_bank;
    logic        emu_mode, idx8_mode;
    logic [23:0] ea_addr, dummy_addr;
    logic        skip_next;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    eag_top dut_i (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .op_lo(op_lo), .op_hi(op_hi),
        .x_idx(x_idx), .y_idx(y_idx), .dp_reg(dp_reg), .data_bank(data_bank),
        .emu_mode(emu_mode), .idx8_mode(idx8_mode), .ea_addr(ea_addr),
        .dummy_addr(dummy_addr), .skip_next(skip_next)
    );

    typedef struct packed {
        logic [3:0]  mode;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] dp;
        logic [7:0]  bank;
        logic        emu;
        logic        i8;
        logic [23:0] exp_ea;
        logic [23:0] exp_dummy;
        logic        exp_skip;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  8'h34, 8'h12, 16'h0000, 16'h0000, 16'h0000, 8'h7E, 1'b0, 1'b0, 24'h7E1234, 24'h000000, 1'b0},
        '{4'd1,  8'hF0, 8'h12, 16'h0020, 16'h0000, 16'h0000, 8'h01, 1'b0, 1'b1, 24'h011310, 24'h011210, 1'b0},
        '{4'd2,  8'h10, 8'h12, 16'h0005, 16'h0000, 16'h0000, 8'h02, 1'b0, 1'b1, 24'h021215, 24'h021215, 1'b1},
        '{4'd2,  8'hF0, 8'h12, 16'h0020, 16'h0000, 16'h0000, 8'h02, 1'b0, 1'b1, 24'h021310, 24'h021210, 1'b0},
        '{4'd2,  8'h10, 8'h12, 16'h0105, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 24'h001315, 24'h001215, 1'b0},
        '{4'd4,  8'h00, 8'h40, 16'h0000, 16'h0033, 16'h0000, 8'h05, 1'b1, 1'b0, 24'h054033, 24'h054033, 1'b1},
        '{4'd3,  8'hFF, 8'hFF, 16'h0000, 16'h0001, 16'h0000, 8'h7F, 1'b0, 1'b1, 24'h800000, 24'h7FFF00, 1'b0},
        '{4'd5,  8'h42, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0, 1'b0, 24'h000042, 24'h000000, 1'b1},
        '{4'd5,  8'h42, 8'h00, 16'h0000, 16'h0000, 16'h0101, 8'h09, 1'b0, 1'b0, 24'h000143, 24'h000000, 1'b0},
        '{4'd6,  8'h10, 8'h00, 16'h0005, 16'h0000, 16'h2000, 8'h00, 1'b0, 1'b1, 24'h002015, 24'h000000, 1'b1},
        '{4'd7,  8'h20, 8'h00, 16'h0000, 16'h0001, 16'hFFF0, 8'h00, 1'b0, 1'b1, 24'h000011, 24'h000000, 1'b0},
        '{4'd8,  8'h04, 8'h00, 16'h0002, 16'h0000, 16'h0300, 8'h12, 1'b0, 1'b1, 24'h000306, 24'h000000, 1'b1},
        '{4'd9,  8'h05, 8'h00, 16'h9999, 16'h0000, 16'h0080, 8'h00, 1'b0, 1'b0, 24'h000085, 24'h000000, 1'b0},
        '{4'd12, 8'h55, 8'h66, 16'h0001, 16'h0002, 16'h0000, 8'h33, 1'b0, 1'b1, 24'h000000, 24'h000000, 1'b0}
    };

    // Requirement tag for the address of a mode code.
    function automatic string ea_tag(input logic [3:0] m);
        if (m == 4'd0)      return "R3";
        else if (m <= 4'd4) return "R4";
        else if (m <= 4'd9) return "R8";
        else                return "R10";
    endfunction

    // Requirement tag for the skip flag of a mode code.
    function automatic string skip_tag(input logic [3:0] m);
        if (m == 4'd0)                   return "R3";
        else if (m == 4'd1 || m == 4'd3) return "R6";
        else if (m <= 4'd4)              return "R5";
        else if (m <= 4'd9)              return "R9";
        else                             return "R10";
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        mode_sel  = v.mode;
        op_lo     = v.lo;
        op_hi     = v.hi;
        x_idx     = v.x;
        y_idx     = v.y;
        dp_reg    = v.dp;
        data_bank = {v.bank, 16'h0000};
        emu_mode  = v.emu;
        idx8_mode = v.i8;
    endtask

    initial begin
        vec_t v;
        rst_n = 1'b0;
        apply(VECS[1]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears outputs even with live inputs.
        check("R1", "ea_addr", ea_addr, 24'h0);
        check("R1", "dummy_addr", dummy_addr, 24'h0);
        check("R1", "skip_next", {23'h0, skip_next}, 24'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            v = VECS[i];
            apply(v);
            @(posedge clk);
            @(negedge clk);
            check(ea_tag(v.mode), "ea_addr", ea_addr, v.exp_ea);
            check((v.mode >= 4'd1 && v.mode <= 4'd4) ? "R7" : "R7/R10",
                  "dummy_addr", dummy_addr, v.exp_dummy);
            check(skip_tag(v.mode), "skip_next", {23'h0, skip_next}, {23'h0, v.exp_skip});
        end

        // R2: a new input between edges leaves the outputs unchanged.
        apply(VECS[0]);
        @(posedge clk);
        @(negedge clk);
        apply(VECS[2]);
        #2;
        check("R2", "ea_addr held", ea_addr, 24'h7E1234);
        check("R2", "skip held", {23'h0, skip_next}, 24'h0);
        @(posedge clk);
        @(negedge clk);
        check("R2", "ea_addr next edge", ea_addr, 24'h021215);

        // R5: carry out of the low byte, 8-bit index: no skip.
        v = VECS[2];
        v.lo = 8'hFF; v.x = 16'h0001;
        apply(v);
        @(posedge clk);
        @(negedge clk);
        check("R5", "carry skip", {23'h0, skip_next}, 24'h0);
        check("R7", "carry dummy", dummy_addr, 24'h0212_00);

        // R5: no carry, both flags clear, zero index: no skip.
        v.lo = 8'h10; v.x = 16'h0000; v.i8 = 1'b0; v.emu = 1'b0;
        apply(v);
        @(posedge clk);
        @(negedge clk);
        check("R5", "16-bit skip", {23'h0, skip_next}, 24'h0);

        // R10: highest unused code.
        v = VECS[13];
        v.mode = 4'd15;
        apply(v);
        @(posedge clk);
        @(negedge clk);
        check("R10", "code 15 ea", ea_addr, 24'h0);
        check("R10", "code 15 skip", {23'h0, skip_next}, 24'h0);

        // R1: reset mid-run clears outputs again.
        apply(VECS[0]);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", "mid-run reset", ea_addr, 24'h0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule